// File: doc/BRIEF.md
# Three-Source Monitor Raster Scanner

This block turns the contents of a small word-organised machine into a digital raster for a monitor display. Each frame has 32 raster lines, and each line has 32 digits. A one-hot selector chooses what the frame shows:

- **Store view:** each raster line shows the store word with the same index.
- **Accumulator view:** the single accumulator word is repeated on every line.
- **Control view:** the content depends on whether the machine is running.
  - While it runs, the current-instruction address word and the present-instruction word alternate from line to line.
  - While it is stopped, only the address word is shown, on every line.

For each digit period the block emits:

- the raster line index and the digit index;
- the digit value (a zero is drawn as a dot, a one as a dash);
- a line-valid flag that is low during a four-digit blanking gap between lines;
- a brighten flag that marks the action line.

The store is read through a 5-bit address port. The block assumes the addressed word is stable within a few cycles. The word for each raster line is captured during the last blanking slot before that line.

Top module: `mon_raster`

## Requirements
- R1: While reset is held, and for the first four clocks after reset is released, `line_valid`, `brighten` and `digit_val` are low. On the fourth clock the scan is at line 0, digit 0. After reset the selected source is the store.
- R2: Each raster line has 32 visible digits, indexed 0 to 31 in that order with `line_valid` high. Four blanking clocks follow, with `line_valid` low. Line indices run 0 to 31 and then wrap to 0.
- R3: With `src_sel` = 3'b001 (store), raster line n shows store word n. Digit d carries bit d of the word, so bit 0 (the least significant bit) is shown first.
- R4: With `src_sel` = 3'b010 (accumulator), every raster line shows `acc_word`.
- R5: With `src_sel` = 3'b100 (control) and `running` high, even raster lines show `ci_word` and odd raster lines show `pi_word`.
- R6: With `src_sel` = 3'b100 and `running` low, every raster line shows `ci_word`.
- R7: `brighten` is high on exactly the visible digits of the raster line whose index equals `action_line`. It is low during blanking.
- R8: A `src_sel` value that is not one-hot (zero bits set, or more than one) is ignored, and the previously selected source stays in effect.
- R9: A line's word is captured in the last blanking clock before the line. A change to the source inputs during the line's visible digits does not alter that line, and takes effect from the next line.
- R10: `store_addr` always equals (`raster_line` + 1) mod 32, the index of the line to be fetched next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 3 | One-hot source selection: bit 0 store, bit 1 accumulator, bit 2 control |
| running | input | 1 | High while the machine executes instructions |
| action_line | input | 5 | Index of the line to brighten |
| acc_word | input | 32 | Accumulator word |
| ci_word | input | 32 | Current-instruction address word |
| pi_word | input | 32 | Present-instruction word |
| store_addr | output | 5 | Store read address |
| store_data | input | 32 | Store word at `store_addr` |
| raster_line | output | 5 | Current raster line index |
| raster_digit | output | 5 | Current digit index (0 in blanking) |
| digit_val | output | 1 | Digit value, 1 = dash, 0 = dot (0 in blanking) |
| line_valid | output | 1 | High on visible digits, low in blanking |
| brighten | output | 1 | High on visible digits of the action line |

## Verification
Full frames are captured under the store, accumulator, running-control and stopped-control views, with the action line at 0, in mid-frame and at 31.

- The store view is loaded with a distinct word per line, so a wrong line index or a reversed digit order shows up as a mismatch.
- The running-control view uses different address and instruction words, so swapped parity or a missing alternation is detected.
- Zero and multi-bit selector values are applied after a store selection, with distinct accumulator and control words, so any unintended switch of source is visible.
- The accumulator is changed in the middle of a line, which separates capture at the line boundary from live reading.

// File: rtl/mon_raster_pkg.sv
// Package: mon_raster_pkg
// Shared selector encoding for the monitor raster scanner.
// Assumes a three-way one-hot selector: store, accumulator, control.
package mon_raster_pkg;
    localparam int SRC_STORE_BIT = 0;
    localparam int SRC_ACC_BIT   = 1;
    localparam int SRC_CTRL_BIT  = 2;
    localparam int SRC_N         = 3;

    typedef logic [SRC_N-1:0] src_sel_t;

    localparam src_sel_t SRC_RESET = src_sel_t'(1 << SRC_STORE_BIT);
endpackage

// File: rtl/mon_raster_timing.sv
// Module: mon_raster_timing
// Generates the digit and line counters of the raster: WORD_W visible
// digit slots followed by GAP_W blanking slots per line, LINES lines per
// frame. Assumes LINES is a power of two so the line index wraps naturally.
// Reset parks the scan on the first blanking slot of the last line, so the
// first visible line after reset is line 0.
module mon_raster_timing #(
    parameter int WORD_W = 32,
    parameter int GAP_W  = 4,
    parameter int LINES  = 32,
    localparam int POS_N  = WORD_W + GAP_W,
    localparam int POS_W  = $clog2(POS_N),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [POS_W-1:0]  pos_q,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] next_line,
    output logic              vis,
    output logic              load
);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(POS_N - 1);
    localparam logic [POS_W-1:0]  POS_VIS   = POS_W'(WORD_W);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

    // Index of the line that follows the current one, wrapping at the end.
    assign next_line = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    // Last blanking slot: the next line's word is captured here.
    assign load = (pos_q == POS_LAST);
    // Visible digit slots are the first WORD_W positions of a line.
    assign vis  = (pos_q < POS_VIS);

    // Step the digit position and advance the line at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_VIS;
            line_q <= LINE_LAST;
        end else if (load) begin
            pos_q  <= '0;
            line_q <= next_line;
        end else begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(line_q));
    assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && line_q != LINE_LAST) |=> (line_q == $past(line_q) + 1'b1) && (pos_q == '0));
    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && line_q == LINE_LAST) |=> (line_q == '0) && (pos_q == '0));
endmodule

// File: rtl/mon_raster_srcsel.sv
// Module: mon_raster_srcsel
// Holds the active display source. A one-hot selector value is taken on
// the next clock; any other value leaves the held source unchanged.
// Assumes the selector is quasi-static (front-panel style buttons).
module mon_raster_srcsel
    import mon_raster_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_t sel_i,
    output src_sel_t src_q
);
    // Register the selection only when exactly one source is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_RESET;
        end else if ($onehot(sel_i)) begin
            src_q <= sel_i;
        end
    end

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(sel_i) |=> $stable(src_q));
    assert_sel_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel_i) |=> (src_q == $past(sel_i)));
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(src_q));
endmodule

// File: rtl/mon_raster_fetch.sv
// Module: mon_raster_fetch
// Chooses the word for the next raster line from the held source and
// captures it on the load strobe. Assumes store_data_i already reflects
// the next line's address when load is high. In the control view the
// present-instruction word goes to odd lines only while running.
module mon_raster_fetch
    import mon_raster_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_sel_t          src_q,
    input  logic              running_i,
    input  logic              next_odd_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] ci_i,
    input  logic [WORD_W-1:0] pi_i,
    input  logic [WORD_W-1:0] store_data_i,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] pick;

    // Select the candidate word for the upcoming line.
    always_comb begin
        pick = store_data_i;
        if (src_q[SRC_ACC_BIT]) begin
            pick = acc_i;
        end else if (src_q[SRC_CTRL_BIT]) begin
            pick = (running_i && next_odd_i) ? pi_i : ci_i;
        end
    end

    // Capture the line word in the last blanking slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= pick;
        end
    end

    assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_q));
    assert_acc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && src_q[SRC_ACC_BIT]) |=> (word_q == $past(acc_i)));
    assert_ctrl_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && src_q[SRC_CTRL_BIT] && !running_i) |=> (word_q == $past(ci_i)));
endmodule

// File: rtl/mon_raster.sv
// Module: mon_raster
// Top of the three-source monitor raster scanner. Combines the raster
// counters, the source hold register and the line-word capture, and
// drives the per-digit output stream. Assumes a store whose read data
// settles within the blanking gap after store_addr changes.
module mon_raster
    import mon_raster_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int GAP_W  = 4,
    parameter int LINES  = 32,
    localparam int POS_N  = WORD_W + GAP_W,
    localparam int POS_W  = $clog2(POS_N),
    localparam int LINE_W = $clog2(LINES),
    localparam int DIG_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        src_sel,
    input  logic              running,
    input  logic [LINE_W-1:0] action_line,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [WORD_W-1:0] ci_word,
    input  logic [WORD_W-1:0] pi_word,
    output logic [LINE_W-1:0] store_addr,
    input  logic [WORD_W-1:0] store_data,
    output logic [LINE_W-1:0] raster_line,
    output logic [DIG_W-1:0]  raster_digit,
    output logic              digit_val,
    output logic              line_valid,
    output logic              brighten
);
    logic [POS_W-1:0]  pos_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] next_line;
    logic              vis;
    logic              load;
    src_sel_t          src_q;
    logic [WORD_W-1:0] word_q;
    logic [DIG_W-1:0]  dig;

    mon_raster_timing #(
        .WORD_W (WORD_W),
        .GAP_W  (GAP_W),
        .LINES  (LINES)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_q     (pos_q),
        .line_q    (line_q),
        .next_line (next_line),
        .vis       (vis),
        .load      (load)
    );

    mon_raster_srcsel u_srcsel (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (src_sel),
        .src_q (src_q)
    );

    mon_raster_fetch #(
        .WORD_W (WORD_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_q        (src_q),
        .running_i    (running),
        .next_odd_i   (next_line[0]),
        .load_i       (load),
        .acc_i        (acc_word),
        .ci_i         (ci_word),
        .pi_i         (pi_word),
        .store_data_i (store_data),
        .word_q       (word_q)
    );

    // Digit index within the line, taken from the low bits of the position.
    assign dig = pos_q[DIG_W-1:0];

    // Drive the per-digit stream, blanking everything outside visible slots.
    always_comb begin
        store_addr   = next_line;
        raster_line  = line_q;
        line_valid   = vis;
        raster_digit = vis ? dig : '0;
        digit_val    = vis ? word_q[dig] : 1'b0;
        brighten     = vis && (line_q == action_line);
    end

    assert_bright_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brighten |-> (line_valid && raster_line == action_line));
    assert_addr_ahead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (raster_line == $past(store_addr)));
    assert_blank_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |-> (!digit_val && !brighten));
endmodule

// File: tb/mon_raster_tb.sv
// Bench for mon_raster: a vector table of view settings walked over full
// frames, then directed tests for reset, selector hold and mid-line change.
module mon_raster_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = 3'b001;
    logic        running = 1'b0;
    logic [4:0]  action_line = 5'd0;
    logic [31:0] acc_word = 32'hA5C3_0F81;
    logic [31:0] ci_word  = 32'h0000_1234;
    logic [31:0] pi_word  = 32'h8001_7E6D;
    logic [4:0]  store_addr;
    logic [31:0] store_data;
    logic [4:0]  raster_line;
    logic [4:0]  raster_digit;
    logic        digit_val;
    logic        line_valid;
    logic        brighten;

    logic [31:0] mem [32];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign store_data = mem[store_addr];

    mon_raster u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_sel      (src_sel),
        .running      (running),
        .action_line  (action_line),
        .acc_word     (acc_word),
        .ci_word      (ci_word),
        .pi_word      (pi_word),
        .store_addr   (store_addr),
        .store_data   (store_data),
        .raster_line  (raster_line),
        .raster_digit (raster_digit),
        .digit_val    (digit_val),
        .line_valid   (line_valid),
        .brighten     (brighten)
    );

    // Vectors: [8:6] selector, [5] running, [4:0] action line
    localparam logic [8:0] VEC [6] = '{
        {3'b001, 1'b0, 5'd5},
        {3'b010, 1'b0, 5'd0},
        {3'b100, 1'b1, 5'd31},
        {3'b100, 1'b0, 5'd12},
        {3'b001, 1'b1, 5'd17},
        {3'b010, 1'b1, 5'd31}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [2:0] sel, input logic run, input int ln);
        if (sel == 3'b001) return mem[ln];
        if (sel == 3'b010) return acc_word;
        if (run) return (ln % 2 == 0) ? ci_word : pi_word;
        return ci_word;
    endfunction

    function automatic string req_of(input logic [2:0] sel, input logic run);
        if (sel == 3'b001) return "R3 store line";
        if (sel == 3'b010) return "R4 accumulator";
        if (run) return "R5 control running";
        return "R6 control stopped";
    endfunction

    task automatic wait_frame();
        repeat (2) @(negedge clk);
        while (!(line_valid && raster_line == 5'd0 && raster_digit == 5'd0)) @(negedge clk);
    endtask

    // Capture one full frame starting at line 0 digit 0 and compare it.
    task automatic capture_frame(input logic [2:0] sel, input logic run, input logic [4:0] act);
        for (int ln = 0; ln < 32; ln++) begin
            logic [31:0] w = '0;
            logic [31:0] bm = '0;
            bit idx_ok = 1'b1;
            bit addr_ok = 1'b1;
            for (int d = 0; d < 32; d++) begin
                w[d] = digit_val;
                bm[d] = brighten;
                if (!line_valid || raster_digit != 5'(d) || raster_line != 5'(ln)) idx_ok = 1'b0;
                if (store_addr != 5'((ln + 1) % 32)) addr_ok = 1'b0;
                @(negedge clk);
            end
            for (int g = 0; g < 4; g++) begin
                if (line_valid || brighten || digit_val) idx_ok = 1'b0;
                if (store_addr != 5'((ln + 1) % 32)) addr_ok = 1'b0;
                @(negedge clk);
            end
            check(w == exp_word(sel, run, ln), req_of(sel, run), w, exp_word(sel, run, ln));
            check(bm == ((5'(ln) == act) ? 32'hFFFF_FFFF : 32'h0), "R7 brighten", bm,
                  (5'(ln) == act) ? 32'hFFFF_FFFF : 32'h0);
            check(idx_ok, "R2 line/digit order", {31'b0, idx_ok}, 32'd1);
            check(addr_ok, "R10 store address", {27'b0, store_addr}, 32'((ln + 2) % 32));
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ (i << 7) ^ 32'h1;

        // R1: reset state and first visible slot
        repeat (3) @(negedge clk);
        check(!line_valid && !brighten && !digit_val, "R1 in reset", {29'b0, line_valid, brighten, digit_val}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!line_valid && !brighten && !digit_val, "R1 blank after release", {29'b0, line_valid, brighten, digit_val}, 32'd0);
        @(negedge clk);
        check(line_valid && raster_line == 5'd0 && raster_digit == 5'd0, "R1 first slot",
              {22'b0, line_valid, raster_line, raster_digit}, {22'b0, 1'b1, 10'd0});
        // R1: default source is the store (action line 0 at reset)
        capture_frame(3'b001, 1'b0, 5'd0);

        // Table walk over the views
        for (int v = 0; v < 6; v++) begin
            src_sel = VEC[v][8:6];
            running = VEC[v][5];
            action_line = VEC[v][4:0];
            wait_frame();
            capture_frame(VEC[v][8:6], VEC[v][5], VEC[v][4:0]);
        end

        // R8: zero and multi-bit selectors keep the store view
        src_sel = 3'b001;
        running = 1'b1;
        action_line = 5'd3;
        repeat (3) @(negedge clk);
        src_sel = 3'b000;
        wait_frame();
        capture_frame(3'b001, 1'b1, 5'd3);
        src_sel = 3'b110;
        wait_frame();
        capture_frame(3'b001, 1'b1, 5'd3);

        // R9: accumulator change in mid-line affects only the next line
        begin
            logic [31:0] old_acc = 32'h1357_9BDF;
            logic [31:0] new_acc = 32'hE0F0_0C3A;
            logic [31:0] w = '0;
            acc_word = old_acc;
            src_sel = 3'b010;
            wait_frame();
            while (!(line_valid && raster_line == 5'd3 && raster_digit == 5'd10)) @(negedge clk);
            acc_word = new_acc;
            for (int d = 10; d < 32; d++) begin
                w[d] = digit_val;
                @(negedge clk);
            end
            check(w[31:10] == old_acc[31:10], "R9 current line unchanged", {10'b0, w[31:10]}, {10'b0, old_acc[31:10]});
            repeat (4) @(negedge clk);
            for (int d = 0; d < 32; d++) begin
                w[d] = digit_val;
                @(negedge clk);
            end
            check(w == new_acc, "R9 next line updated", w, new_acc);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule